// File: doc/BRIEF.md
# Frame Timestamp Capture Unit

This block keeps a free-running time-of-day count (seconds, nanoseconds and a one-bit epoch) and latches it in hardware at the moment a start-of-frame strobe arrives from the MAC-side data path. A fixed path-latency term is then applied. Received frames have their ingress term subtracted. Transmitted frames have their egress term added. The corrected stamp, the frame's sequence tag and its direction are queued in a small FIFO. A time servo or host drains that FIFO through a valid/ready stream port.

Two saturating health counters watch the queue. One counts captures lost because the FIFO was full. The other counts stamps that waited longer than a programmable number of cycles before they were read. Every stamp carries the epoch bit, which toggles each time the seconds field wraps, so a consumer can extend the time without a discontinuity. A one-cycle wrap pulse also marks each seconds wrap of the live counter.

The output stream follows valid/ready rules. A stamp is removed only in a cycle where both valid and ready are high. While valid is high and ready is low, every output field holds its value. Ready may be held low for as long as the consumer wishes. New captures then build up in the FIFO, and once it is full they are counted as missing.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset the time count is 0 s, 0 ns, epoch 0. It advances by NS_STEP nanoseconds every clock. The nanoseconds field rolls over at NS_ROLL into the seconds field. When the seconds field wraps from all ones to zero, the epoch toggles and `wrap_o` is high for exactly that one cycle.
- R2: When `sfd_i` is high at a clock edge, the time value held during that cycle is latched together with `dir_i` and `seq_i`. If the FIFO is empty, the stamp is offered on the output two edges later.
- R3: Direction 0 (ingress) subtracts `lat_ing_i`, and direction 1 (egress) adds `lat_egr_i`. A borrow or carry passes between the nanoseconds field, the seconds field and the epoch bit. Both latency inputs are below NS_ROLL, so the output nanoseconds field is always below NS_ROLL.
- R4: The fields {epoch, seconds, nanoseconds} of each stamp equal the latched time plus or minus the latency, taken modulo 2^(SEC_W+1) seconds. This lets a consumer unwrap the stamps with no gap or jump.
- R5: Captures on consecutive cycles are all queued while there is room, and they leave the FIFO in capture order.
- R6: A capture that reaches a full FIFO in a cycle with no pop is not stored and increments `miss_cnt_o`. Stamps already queued are kept unchanged.
- R7: A stamp's age is the number of edges since it was written, minus one. `ts_late_o` is high when the head stamp's age exceeds `age_lim_i`. Popping a stamp that is flagged late increments `late_cnt_o`.
- R8: Both health counters stop at their all-ones value. A pulse on `miss_clr_i` or `late_clr_i` sets the matching counter to zero at the next edge. A clear takes priority over an increment in the same cycle.
- R9: On the output stream a pop happens only when valid and ready are both high. While valid is high and ready is low, all output fields are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and capture clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfd_i | input | 1 | Start-of-frame capture strobe |
| dir_i | input | 1 | Frame direction: 0 ingress, 1 egress |
| seq_i | input | SEQ_W | Sequence tag of the frame |
| lat_ing_i | input | NS_W | Ingress latency in ns, below NS_ROLL |
| lat_egr_i | input | NS_W | Egress latency in ns, below NS_ROLL |
| age_lim_i | input | AGE_W | Age limit in cycles for the late flag |
| miss_clr_i | input | 1 | Clear pulse for the missing counter |
| late_clr_i | input | 1 | Clear pulse for the late counter |
| ts_valid_o | output | 1 | Stamp available |
| ts_ready_i | input | 1 | Consumer accepts the stamp |
| ts_sec_o | output | SEC_W | Corrected seconds |
| ts_ns_o | output | NS_W | Corrected nanoseconds |
| ts_epoch_o | output | 1 | Epoch bit of the corrected stamp |
| ts_dir_o | output | 1 | Direction of the stamp |
| ts_seq_o | output | SEQ_W | Sequence tag of the stamp |
| ts_late_o | output | 1 | Head stamp is older than the age limit |
| wrap_o | output | 1 | One-cycle pulse on a seconds wrap |
| miss_cnt_o | output | CNT_W | Saturating count of missing stamps |
| late_cnt_o | output | CNT_W | Saturating count of late stamps |

## Verification
A strobe driven before edge E is latched at E and written to the FIFO at E+1, so the bench reads the stamp at the falling edge after E+1. It compares that stamp with a value computed from its own count of edges since reset: k times NS_STEP, plus or minus the latency, reduced modulo the epoch period. The wrap pulse is due in the cycle right after the edge that completes a seconds period, and it is compared on every falling edge. A counter update is due one edge after the dropped write, the late pop or the clear pulse that causes it. The late flag is sampled exactly n edges after the write edge, with n placed on either side of the limit.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic {
    DIR_INGRESS = 1'b0,
    DIR_EGRESS  = 1'b1
  } dir_e;
endpackage

// File: rtl/ts_tod_counter.sv
module ts_tod_counter #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter logic [NS_W-1:0] NS_ROLL = 32'd1_000_000_000,
  parameter logic [NS_W-1:0] NS_STEP = 32'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o,
  output logic             epoch_o,
  output logic             wrap_o
);
  localparam logic [NS_W:0] ROLL_X = {1'b0, NS_ROLL};

  logic [NS_W:0]  ns_sum;
  logic           carry;
  logic [NS_W:0]  ns_wrapped;

  assign ns_sum     = {1'b0, ns_o} + {1'b0, NS_STEP};
  assign carry      = ns_sum >= ROLL_X;
  assign ns_wrapped = ns_sum - ROLL_X;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_o   <= '0;
      ns_o    <= '0;
      epoch_o <= 1'b0;
      wrap_o  <= 1'b0;
    end else begin
      ns_o   <= carry ? ns_wrapped[NS_W-1:0] : ns_sum[NS_W-1:0];
      wrap_o <= carry && (sec_o == '1);
      if (carry) {epoch_o, sec_o} <= {epoch_o, sec_o} + 1'b1;
    end
  end

  // R1: nanoseconds never reach the rollover value
  p_ns_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ns_o < NS_ROLL);

  // R1: a wrap pulse always coincides with seconds back at zero and a toggled epoch
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (sec_o == '0) && (epoch_o != $past(epoch_o)));
endmodule

// File: rtl/ts_lat_adjust.sv
module ts_lat_adjust
  import ts_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter logic [NS_W-1:0] NS_ROLL = 32'd1_000_000_000
) (
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic             epoch_i,
  input  dir_e             dir_i,
  input  logic [NS_W-1:0]  lat_ing_i,
  input  logic [NS_W-1:0]  lat_egr_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o,
  output logic             epoch_o
);
  localparam logic [NS_W:0] ROLL_X = {1'b0, NS_ROLL};

  logic [NS_W:0] add_sum, add_wrap, sub_plain, sub_wrap;
  logic          carry, borrow;

  always_comb begin
    add_sum   = {1'b0, ns_i} + {1'b0, lat_egr_i};
    add_wrap  = add_sum - ROLL_X;
    carry     = add_sum >= ROLL_X;
    borrow    = ns_i < lat_ing_i;
    sub_plain = {1'b0, ns_i} - {1'b0, lat_ing_i};
    sub_wrap  = {1'b0, ns_i} + ROLL_X - {1'b0, lat_ing_i};
    if (dir_i == DIR_EGRESS) begin
      ns_o             = carry ? add_wrap[NS_W-1:0] : add_sum[NS_W-1:0];
      {epoch_o, sec_o} = {epoch_i, sec_i} + {{SEC_W{1'b0}}, carry};
    end else begin
      ns_o             = borrow ? sub_wrap[NS_W-1:0] : sub_plain[NS_W-1:0];
      {epoch_o, sec_o} = {epoch_i, sec_i} - {{SEC_W{1'b0}}, borrow};
    end
  end
endmodule

// File: rtl/ts_stamp_fifo.sv
module ts_stamp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AGE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  output logic             wr_drop_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [W-1:0]     rd_data_o,
  output logic [AGE_W-1:0] head_age_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]     mem   [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             full, push, pop;

  assign full       = cnt == FULL_CNT;
  assign rd_valid_o = cnt != '0;
  assign pop        = rd_valid_o && rd_ready_i;
  assign push       = wr_en_i && (!full || pop);
  assign wr_drop_o  = wr_en_i && !push;
  assign rd_data_o  = mem[rp];
  assign head_age_o = age_q[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                          age_q[g] <= '0;
      else if (push && wp == AW'(g))       age_q[g] <= '0;
      else if (age_q[g] != '1)             age_q[g] <= age_q[g] + 1'b1;
    end
  end

  // R6: occupancy never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R9: a stalled head stays put
  p_hold_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
endmodule

// File: rtl/ts_sat_counter.sv
module ts_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end

  // R8: a saturated counter stays saturated until cleared
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '1) && !clr_i |=> cnt_o == '1);

  // R8: clear wins over increment
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 32,
  parameter logic [NS_W-1:0] NS_ROLL = 32'd1_000_000_000,
  parameter logic [NS_W-1:0] NS_STEP = 32'd8,
  parameter int SEQ_W = 16,
  parameter int DEPTH = 16,
  parameter int AGE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfd_i,
  input  logic             dir_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [NS_W-1:0]  lat_ing_i,
  input  logic [NS_W-1:0]  lat_egr_i,
  input  logic [AGE_W-1:0] age_lim_i,
  input  logic             miss_clr_i,
  input  logic             late_clr_i,
  output logic             ts_valid_o,
  input  logic             ts_ready_i,
  output logic [SEC_W-1:0] ts_sec_o,
  output logic [NS_W-1:0]  ts_ns_o,
  output logic             ts_epoch_o,
  output logic             ts_dir_o,
  output logic [SEQ_W-1:0] ts_seq_o,
  output logic             ts_late_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] late_cnt_o
);
  localparam int ENT_W = SEC_W + NS_W + 2 + SEQ_W;

  logic [SEC_W-1:0] tod_sec, stg_sec, adj_sec;
  logic [NS_W-1:0]  tod_ns, stg_ns, adj_ns;
  logic             tod_ep, stg_ep, adj_ep, stg_v;
  dir_e             stg_dir;
  logic [SEQ_W-1:0] stg_seq;
  logic [ENT_W-1:0] wr_ent, rd_ent;
  logic [AGE_W-1:0] head_age;
  logic             drop, pop, late_now;

  ts_tod_counter #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_ROLL(NS_ROLL), .NS_STEP(NS_STEP)) u_tod (
    .clk(clk), .rst_n(rst_n), .sec_o(tod_sec), .ns_o(tod_ns), .epoch_o(tod_ep), .wrap_o(wrap_o));

  // capture latch: the marker edge freezes the live time value
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v   <= 1'b0;
      stg_sec <= '0;
      stg_ns  <= '0;
      stg_ep  <= 1'b0;
      stg_dir <= DIR_INGRESS;
      stg_seq <= '0;
    end else begin
      stg_v <= sfd_i;
      if (sfd_i) begin
        stg_sec <= tod_sec;
        stg_ns  <= tod_ns;
        stg_ep  <= tod_ep;
        stg_dir <= dir_e'(dir_i);
        stg_seq <= seq_i;
      end
    end
  end

  ts_lat_adjust #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_ROLL(NS_ROLL)) u_adj (
    .sec_i(stg_sec), .ns_i(stg_ns), .epoch_i(stg_ep), .dir_i(stg_dir),
    .lat_ing_i(lat_ing_i), .lat_egr_i(lat_egr_i),
    .sec_o(adj_sec), .ns_o(adj_ns), .epoch_o(adj_ep));

  assign wr_ent = {adj_sec, adj_ns, adj_ep, stg_dir, stg_seq};

  ts_stamp_fifo #(.W(ENT_W), .DEPTH(DEPTH), .AGE_W(AGE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en_i(stg_v), .wr_data_i(wr_ent), .wr_drop_o(drop),
    .rd_valid_o(ts_valid_o), .rd_ready_i(ts_ready_i), .rd_data_o(rd_ent), .head_age_o(head_age));

  assign {ts_sec_o, ts_ns_o, ts_epoch_o, ts_dir_o, ts_seq_o} = rd_ent;
  assign pop       = ts_valid_o && ts_ready_i;
  assign late_now  = ts_valid_o && (head_age > age_lim_i);
  assign ts_late_o = late_now;

  ts_sat_counter #(.W(CNT_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc_i(drop), .clr_i(miss_clr_i), .cnt_o(miss_cnt_o));

  ts_sat_counter #(.W(CNT_W)) u_late (
    .clk(clk), .rst_n(rst_n), .inc_i(pop && late_now), .clr_i(late_clr_i), .cnt_o(late_cnt_o));

  // R3: corrected nanoseconds stay inside the field range
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid_o |-> ts_ns_o < NS_ROLL);

  // R6: a capture meeting a full, unpopped queue bumps the missing count
  p_miss_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stg_v && drop && !miss_clr_i && (miss_cnt_o != '1) |=> miss_cnt_o == $past(miss_cnt_o) + 1'b1);

  // R2: a latched capture always yields a stamp on the stream next cycle
  p_capture_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stg_v && !drop |=> ts_valid_o);
endmodule

// File: tb/ts_capture_unit_test.sv
`timescale 1ns/1ps
module ts_capture_unit_test;
  localparam int SW = 3, NW = 8, QW = 16, D = 4, AGW = 4, CW = 3;
  localparam longint ROLL = 100, STEP = 8;
  localparam longint PERIOD = ROLL * (64'd1 << (SW + 1));

  logic clk = 0, rst_n = 0;
  logic sfd = 0, dir = 0, rdy = 0, mclr = 0, lclr = 0;
  logic [QW-1:0] seq = '0;
  logic [NW-1:0] lat_i = '0, lat_e = '0;
  logic [AGW-1:0] alim = '1;
  logic vld, ep_o, dir_o, late_o, wrap;
  logic [SW-1:0] sec_o;
  logic [NW-1:0] ns_o;
  logic [QW-1:0] seq_o;
  logic [CW-1:0] miss, latec;

  int checks = 0, errors = 0;
  longint k = 0;
  bit mon = 0, done = 0;

  ts_capture_unit #(.SEC_W(SW), .NS_W(NW), .NS_ROLL(8'd100), .NS_STEP(8'd8),
    .SEQ_W(QW), .DEPTH(D), .AGE_W(AGW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .sfd_i(sfd), .dir_i(dir), .seq_i(seq),
    .lat_ing_i(lat_i), .lat_egr_i(lat_e), .age_lim_i(alim),
    .miss_clr_i(mclr), .late_clr_i(lclr), .ts_valid_o(vld), .ts_ready_i(rdy),
    .ts_sec_o(sec_o), .ts_ns_o(ns_o), .ts_epoch_o(ep_o), .ts_dir_o(dir_o),
    .ts_seq_o(seq_o), .ts_late_o(late_o), .wrap_o(wrap),
    .miss_cnt_o(miss), .late_cnt_o(latec));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  task automatic chk(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // R1: wrap pulse expected in the cycle after the edge completing a seconds period
  always @(negedge clk) begin
    if (rst_n && mon) begin
      bit ew;
      ew = (k >= 1) && (((k * STEP / ROLL) >> SW) != (((k - 1) * STEP / ROLL) >> SW));
      chk("R1 wrap pulse", wrap, ew);
    end
  end

  task automatic drive_cap(input bit d, input int sq, output longint kc);
    @(negedge clk);
    sfd = 1; dir = d; seq = sq[QW-1:0]; kc = k;
  endtask

  task automatic idle();
    @(negedge clk);
    sfd = 0;
  endtask

  // R3/R4: expected stamp from edge count, latency and the epoch period
  task automatic check_pop(input longint kc, input bit d, input int sq, input bit late_e, input string tag);
    longint t, ct, lat;
    lat = d ? longint'(lat_e) : longint'(lat_i);
    t = (kc * STEP) % PERIOD;
    ct = d ? (t + lat) % PERIOD : (t - lat + PERIOD) % PERIOD;
    chk({tag, " R2 valid"}, vld, 1);
    chk({tag, " R4 sec"}, sec_o, (ct / ROLL) % (64'd1 << SW));
    chk({tag, " R3 ns"}, ns_o, ct % ROLL);
    chk({tag, " R4 epoch"}, ep_o, ((ct / ROLL) >> SW) & 1);
    chk({tag, " R2 dir"}, dir_o, d);
    chk({tag, " R5 seq"}, seq_o, sq);
    chk({tag, " R7 late"}, late_o, late_e);
    rdy = 1;
    @(negedge clk);
    rdy = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint kc, kb;
    longint ks [16];
    int s = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", vld, 0);
    chk("R8 reset miss", miss, 0);
    chk("R8 reset late", latec, 0);
    rst_n = 1;
    mon = 1;
    chk("R1 reset wrap", wrap, 0);

    // sweep: latency values x direction x capture time across several epochs
    for (int li = 0; li < 3; li++) begin
      lat_i = (li == 0) ? 8'd0 : (li == 1) ? 8'd37 : 8'd99;
      lat_e = (li == 0) ? 8'd99 : (li == 1) ? 8'd63 : 8'd0;
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < 40; i++) begin
          drive_cap(d[0], s, kc);
          idle();
          @(negedge clk);
          check_pop(kc, d[0], s, 0, "sweep");
          s++;
          repeat (i % 3) @(negedge clk);
        end
      end
    end

    // R5: back-to-back captures, opposite directions
    lat_i = 8'd45; lat_e = 8'd77;
    drive_cap(0, 1000, kc);
    drive_cap(1, 1001, kb);
    idle();
    @(negedge clk);
    check_pop(kc, 0, 1000, 0, "R5 first");
    check_pop(kb, 1, 1001, 0, "R5 second");
    chk("R5 drained", vld, 0);

    // R6: overflow keeps queued stamps, counts the misses
    for (int j = 0; j < 6; j++) drive_cap(j[0], 200 + j, ks[j]);
    idle();
    repeat (3) @(negedge clk);
    chk("R6 miss count", miss, 2);
    for (int j = 0; j < D; j++) check_pop(ks[j], j[0], 200 + j, 0, "R6 kept");
    chk("R6 drained", vld, 0);

    // R8: saturation and clear
    for (int j = 0; j < 12; j++) drive_cap(1, 300 + j, ks[j]);
    idle();
    repeat (3) @(negedge clk);
    chk("R8 miss saturated", miss, 7);
    mclr = 1;
    @(negedge clk);
    mclr = 0;
    chk("R8 miss cleared", miss, 0);
    for (int j = 0; j < D; j++) check_pop(ks[j], 1, 300 + j, 0, "R6 head kept");

    // R7: age limit 3; age n edges after write is n
    alim = 4'd3;
    drive_cap(0, 400, kc);
    idle();
    @(negedge clk);
    repeat (3) @(negedge clk);
    check_pop(kc, 0, 400, 0, "R7 at limit");
    chk("R7 late count unchanged", latec, 0);
    drive_cap(1, 401, kc);
    idle();
    @(negedge clk);
    repeat (4) @(negedge clk);
    check_pop(kc, 1, 401, 1, "R7 over limit");
    chk("R7 late count", latec, 1);
    lclr = 1;
    @(negedge clk);
    lclr = 0;
    chk("R8 late cleared", latec, 0);

    // R9: stalled output holds its fields
    alim = '1;
    drive_cap(0, 500, kc);
    idle();
    repeat (4) @(negedge clk);
    chk("R9 hold valid", vld, 1);
    chk("R9 hold seq", seq_o, 500);
    check_pop(kc, 0, 500, 0, "R9 after stall");
    chk("R9 popped", vld, 0);

    mon = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule